// File: doc/BRIEF.md
# Host Command Mailbox with Result Codes

This block is a polled mailbox between a host processor and a management controller. The host sees three 32-bit registers on a simple register bus:
- a message register, where a write launches a command;
- a response register, which holds the result code;
- an argument register, which carries the operand toward the controller and the return data back.

A zero response means a command is outstanding. Any nonzero value means the previous command has finished.

The normal host sequence has three steps. First the host writes zero to the response register to re-arm it. Then it writes the operand to the argument register. Finally it writes the command ID to the message register. The block raises a one-cycle command strobe with the ID and the operand toward the controller side. When the controller finishes, the block places the result code in the response register. On success it also places the returned data in the argument register.

A built-in command decoder with a configurable completion latency stands in for the controller. With it, the block can be exercised on its own.

Top module: `mbx_responder`

## Requirements
- R1: After reset the response register reads 0x01, and the message and argument registers read 0.
- R2: The message register is at byte offset 0x538, the response register at 0x980 and the argument register at 0x9BC. A read of any other offset returns 0. A write to the argument register while idle is read back unchanged.
- R3: A write of zero to the response register clears it. A write of any nonzero value to the response register leaves it unchanged.
- R4: A message write while no command is outstanding does three things. It drives `cmd_valid` high for exactly one cycle, starting in the cycle after the write. It presents the low 8 bits of the write as `cmd_id` and the argument register as `cmd_arg`. It sets the response register to 0.
- R5: The response stays 0 while a command is outstanding. The result appears LATENCY+1 clock edges after the edge that takes the message write.
- R6: Commands 0x02, 0x04, 0x05 and 0x09 complete with code 0x01. Each replaces the argument with fixed data:
  - 0x02 returns the version value 0x00041A05;
  - 0x04 returns the buffer-address high half 0x00000001;
  - 0x05 returns the buffer-address low half 0xFED80000;
  - 0x09 returns the active-block mask 0x00000FFF.
- R7: Any command ID outside {0x02, 0x04 to 0x09} completes with code 0xFE and leaves the argument unchanged.
- R8: Commands 0x06, 0x07 and 0x08 control logging:
  - 0x06 enables logging and completes with 0x01;
  - 0x07 disables logging, clears the dump count and completes with 0x01;
  - 0x08 while logging is disabled completes with 0xFD and leaves the argument unchanged;
  - 0x08 while logging is enabled completes with 0x01 and returns the dump count plus one, which becomes the new count.
- R9: A message write while a command is outstanding has three effects. It is not forwarded, so no strobe is raised. It does not change the message register. The outstanding command then completes with response 0xFC and leaves the argument unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access valid |
| bus_we | input | 1 | Write enable for the access |
| bus_addr | input | 12 | Byte offset within the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| cmd_valid | output | 1 | One-cycle command launch strobe toward the controller |
| cmd_id | output | 8 | Command ID of the launched command |
| cmd_arg | output | 32 | Operand of the launched command |

## Verification
On every cycle, the assertions check several invariants. The launch strobe is never longer than one cycle. The response stays zero while a command is outstanding. A message that arrives while busy never produces a strobe. A nonzero write to the response register never moves it. Completions happen only while busy and only with legal codes.

Only the bench's scenarios can show the rest. This covers the completion latency and the data and code each command returns. It also covers how the logging commands build on one another across a sequence. The bench checks the reject code and the preserved argument after a colliding message, and the register map seen through reads.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int ID_W   = 8;

  localparam logic [ADDR_W-1:0] OFF_MSG  = 12'h538;
  localparam logic [ADDR_W-1:0] OFF_RESP = 12'h980;
  localparam logic [ADDR_W-1:0] OFF_ARG  = 12'h9BC;

  localparam logic [ID_W-1:0] RC_OK      = 8'h01;
  localparam logic [ID_W-1:0] RC_BUSY    = 8'hFC;
  localparam logic [ID_W-1:0] RC_PREREQ  = 8'hFD;
  localparam logic [ID_W-1:0] RC_UNKNOWN = 8'hFE;
  localparam logic [ID_W-1:0] RC_FAILED  = 8'hFF;

  localparam logic [ID_W-1:0] CMD_VERSION  = 8'h02;
  localparam logic [ID_W-1:0] CMD_BUF_HI   = 8'h04;
  localparam logic [ID_W-1:0] CMD_BUF_LO   = 8'h05;
  localparam logic [ID_W-1:0] CMD_LOG_ON   = 8'h06;
  localparam logic [ID_W-1:0] CMD_LOG_CLR  = 8'h07;
  localparam logic [ID_W-1:0] CMD_DUMP     = 8'h08;
  localparam logic [ID_W-1:0] CMD_BLK_MASK = 8'h09;

  typedef struct packed {
    logic [ID_W-1:0]   code;
    logic [DATA_W-1:0] data;
  } mbx_result_t;

  // Result of one command given the decoder's logging state.
  function automatic mbx_result_t run_cmd(
    input logic [ID_W-1:0]   id,
    input logic [DATA_W-1:0] arg,
    input logic              log_on,
    input logic [DATA_W-1:0] dumps,
    input logic [DATA_W-1:0] ver,
    input logic [DATA_W-1:0] buf_hi,
    input logic [DATA_W-1:0] buf_lo,
    input logic [DATA_W-1:0] blk_mask
  );
    mbx_result_t r;
    r.code = RC_UNKNOWN;
    r.data = arg;
    case (id)
      CMD_VERSION:  begin r.code = RC_OK; r.data = ver;      end
      CMD_BUF_HI:   begin r.code = RC_OK; r.data = buf_hi;   end
      CMD_BUF_LO:   begin r.code = RC_OK; r.data = buf_lo;   end
      CMD_BLK_MASK: begin r.code = RC_OK; r.data = blk_mask; end
      CMD_LOG_ON, CMD_LOG_CLR: r.code = RC_OK;
      CMD_DUMP: begin
        if (log_on) begin
          r.code = RC_OK;
          r.data = dumps + 1'b1;
        end else begin
          r.code = RC_PREREQ;
        end
      end
      default: r.code = RC_UNKNOWN;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/mbx_regfile.sv
module mbx_regfile
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              cmd_valid,
  output logic [ID_W-1:0]   cmd_id,
  output logic [DATA_W-1:0] cmd_arg,
  input  logic              done,
  input  logic [ID_W-1:0]   done_code,
  input  logic [DATA_W-1:0] done_data,
  output logic              busy
);
  localparam int PAD_W = DATA_W - ID_W;

  logic [ID_W-1:0]   msg_q;
  logic [ID_W-1:0]   resp_q;
  logic [DATA_W-1:0] arg_q;
  logic              collided;

  logic wr_any, wr_msg, wr_resp, wr_arg, launch, clash;
  assign wr_any  = bus_sel && bus_we;
  assign wr_msg  = wr_any && (bus_addr == OFF_MSG);
  assign wr_resp = wr_any && (bus_addr == OFF_RESP);
  assign wr_arg  = wr_any && (bus_addr == OFF_ARG);
  assign launch  = wr_msg && !busy;
  assign clash   = wr_msg && busy && !done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_q     <= '0;
      resp_q    <= RC_OK;
      arg_q     <= '0;
      busy      <= 1'b0;
      collided  <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_id    <= '0;
      cmd_arg   <= '0;
    end else begin
      cmd_valid <= launch;
      if (launch) begin
        msg_q    <= bus_wdata[ID_W-1:0];
        cmd_id   <= bus_wdata[ID_W-1:0];
        cmd_arg  <= arg_q;
        resp_q   <= '0;
        busy     <= 1'b1;
        collided <= 1'b0;
      end else if (done) begin
        busy     <= 1'b0;
        collided <= 1'b0;
        resp_q   <= collided ? RC_BUSY : done_code;
        if (!collided && done_code == RC_OK) arg_q <= done_data;
      end else begin
        if (clash) collided <= 1'b1;
        if (wr_resp && bus_wdata == '0) resp_q <= '0;
        if (wr_arg) arg_q <= bus_wdata;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      OFF_MSG:  bus_rdata = {{PAD_W{1'b0}}, msg_q};
      OFF_RESP: bus_rdata = {{PAD_W{1'b0}}, resp_q};
      OFF_ARG:  bus_rdata = arg_q;
      default:  bus_rdata = '0;
    endcase
  end

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  assert_busy_resp_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (resp_q == '0));
  assert_no_forward_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_msg && busy) |=> !cmd_valid);
  assert_resp_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_resp && bus_wdata != '0 && !busy) |=> (resp_q == $past(resp_q)));
endmodule

// File: rtl/mbx_ctrl_model.sv
module mbx_ctrl_model
  import mbx_pkg::*;
#(
  parameter int          LATENCY    = 6,
  parameter logic [31:0] FW_VERSION = 32'h0004_1A05,
  parameter logic [31:0] BUF_HI     = 32'h0000_0001,
  parameter logic [31:0] BUF_LO     = 32'hFED8_0000,
  parameter int          BLOCKS     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [ID_W-1:0]   cmd_id,
  input  logic [DATA_W-1:0] cmd_arg,
  output logic              done,
  output logic [ID_W-1:0]   done_code,
  output logic [DATA_W-1:0] done_data
);
  localparam int CW = $clog2(LATENCY + 1);
  localparam logic [DATA_W-1:0] BLK_MASK = DATA_W'((64'd1 << BLOCKS) - 64'd1);

  logic              active;
  logic [CW-1:0]     cnt;
  logic [ID_W-1:0]   id_q;
  logic [DATA_W-1:0] arg_q;
  logic              log_on;
  logic [DATA_W-1:0] dumps;
  mbx_result_t       res;

  assign res       = run_cmd(id_q, arg_q, log_on, dumps, FW_VERSION, BUF_HI, BUF_LO, BLK_MASK);
  assign done      = active && (cnt == CW'(1));
  assign done_code = res.code;
  assign done_data = res.data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      id_q   <= '0;
      arg_q  <= '0;
      log_on <= 1'b0;
      dumps  <= '0;
    end else begin
      if (cmd_valid) begin
        active <= 1'b1;
        cnt    <= CW'(LATENCY);
        id_q   <= cmd_id;
        arg_q  <= cmd_arg;
      end else if (active) begin
        cnt <= cnt - 1'b1;
        if (done) active <= 1'b0;
      end
      if (done) begin
        case (id_q)
          CMD_LOG_ON: log_on <= 1'b1;
          CMD_LOG_CLR: begin
            log_on <= 1'b0;
            dumps  <= '0;
          end
          CMD_DUMP: if (log_on) dumps <= res.data;
          default: ;
        endcase
      end
    end
  end

  assert_code_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_code == RC_OK || done_code == RC_PREREQ || done_code == RC_UNKNOWN));
endmodule

// File: rtl/mbx_responder.sv
module mbx_responder
  import mbx_pkg::*;
#(
  parameter int          LATENCY    = 6,
  parameter logic [31:0] FW_VERSION = 32'h0004_1A05,
  parameter logic [31:0] BUF_HI     = 32'h0000_0001,
  parameter logic [31:0] BUF_LO     = 32'hFED8_0000,
  parameter int          BLOCKS     = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        cmd_valid,
  output logic [7:0]  cmd_id,
  output logic [31:0] cmd_arg
);
  logic              done;
  logic [ID_W-1:0]   done_code;
  logic [DATA_W-1:0] done_data;
  logic              busy;

  mbx_regfile u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmd_valid(cmd_valid), .cmd_id(cmd_id), .cmd_arg(cmd_arg),
    .done(done), .done_code(done_code), .done_data(done_data),
    .busy(busy)
  );

  mbx_ctrl_model #(
    .LATENCY(LATENCY), .FW_VERSION(FW_VERSION),
    .BUF_HI(BUF_HI), .BUF_LO(BUF_LO), .BLOCKS(BLOCKS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_id(cmd_id), .cmd_arg(cmd_arg),
    .done(done), .done_code(done_code), .done_data(done_data)
  );

  assert_done_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  assert_strobe_from_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (busy && !done));
endmodule

// File: tb/test_mbx_responder.sv
`timescale 1ns/1ps
module test_mbx_responder;
  localparam int LAT = 6;
  localparam logic [11:0] A_MSG = 12'h538, A_RESP = 12'h980, A_ARG = 12'h9BC;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_we = 0;
  logic [11:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic cmd_valid;
  logic [7:0] cmd_id;
  logic [31:0] cmd_arg;

  int checks = 0, errors = 0, pulses = 0;
  bit m_log = 0;
  logic [31:0] m_dumps = 0;

  always #4 clk = ~clk;

  mbx_responder #(.LATENCY(LAT)) i_mbx_responder (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmd_valid(cmd_valid), .cmd_id(cmd_id), .cmd_arg(cmd_arg)
  );

  always @(negedge clk) if (rst_n && cmd_valid) pulses++;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // Expected result code and returned data, written from the requirements.
  function automatic logic [39:0] expect_cmd(input logic [7:0] id, input logic [31:0] arg);
    if (id == 8'h02) return {8'h01, 32'h0004_1A05};
    if (id == 8'h04) return {8'h01, 32'h0000_0001};
    if (id == 8'h05) return {8'h01, 32'hFED8_0000};
    if (id == 8'h09) return {8'h01, 32'h0000_0FFF};
    if (id == 8'h06 || id == 8'h07) return {8'h01, arg};
    if (id == 8'h08) return m_log ? {8'h01, m_dumps + 32'd1} : {8'hFD, arg};
    return {8'hFE, arg};
  endfunction

  task automatic do_cmd(input logic [7:0] id, input logic [31:0] arg);
    logic [39:0] e;
    logic [31:0] r;
    logic [31:0] exp_arg;
    int waits;
    e = expect_cmd(id, arg);
    exp_arg = (e[39:32] == 8'h01) ? e[31:0] : arg;
    bus_write(A_RESP, 0);
    bus_write(A_ARG, arg);
    bus_write(A_MSG, {24'h0, id});
    check(cmd_valid === 1'b1, "R4 strobe", {31'h0, cmd_valid}, 1);
    check(cmd_id === id && cmd_arg === arg, "R4 id/arg", {cmd_id, cmd_arg[23:0]}, {id, arg[23:0]});
    waits = 0;
    bus_read(A_RESP, r);
    while (r == 0 && waits < 1000) begin
      @(negedge clk);
      waits++;
      bus_read(A_RESP, r);
    end
    check(waits == LAT + 1, "R5 latency", waits, LAT + 1);
    check(r == {24'h0, e[39:32]}, "R6/R7/R8 code", r, {24'h0, e[39:32]});
    bus_read(A_ARG, r);
    check(r == exp_arg, "R6/R7/R8 data", r, exp_arg);
    if (id == 8'h06) m_log = 1;
    if (id == 8'h07) begin m_log = 0; m_dumps = 0; end
    if (id == 8'h08 && m_log) m_dumps = m_dumps + 1;
  endtask

  initial begin : watchdog
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] r;
    int p0;
    logic [7:0] tbl[7];
    void'($urandom(32'd1234));
    tbl = '{8'h02, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset values
    bus_read(A_RESP, r); check(r == 32'h1, "R1 resp", r, 1);
    bus_read(A_MSG, r);  check(r == 0, "R1 msg", r, 0);
    bus_read(A_ARG, r);  check(r == 0, "R1 arg", r, 0);

    // R2 map
    bus_read(12'h100, r); check(r == 0, "R2 unmapped", r, 0);
    bus_write(A_ARG, 32'hA5A5_1234);
    bus_read(A_ARG, r); check(r == 32'hA5A5_1234, "R2 arg rw", r, 32'hA5A5_1234);

    // R3 response writes
    bus_write(A_RESP, 32'h0000_0077);
    bus_read(A_RESP, r); check(r == 32'h1, "R3 nonzero ignored", r, 1);
    bus_write(A_RESP, 0);
    bus_read(A_RESP, r); check(r == 0, "R3 zero clears", r, 0);

    // R8 logging sequence
    do_cmd(8'h07, 32'h11);
    do_cmd(8'h08, 32'h22);
    do_cmd(8'h06, 32'h33);
    do_cmd(8'h08, 32'h44);
    do_cmd(8'h08, 32'h55);
    do_cmd(8'h07, 32'h66);
    do_cmd(8'h08, 32'h77);

    // R6 / R7 directed
    do_cmd(8'h02, 32'h0);
    do_cmd(8'h09, 32'h1);
    do_cmd(8'h00, 32'hDEAD_BEEF);
    do_cmd(8'hFF, 32'h1357_9BDF);

    // R9 collision
    p0 = pulses;
    bus_write(A_RESP, 0);
    bus_write(A_ARG, 32'hCAFE_0001);
    bus_write(A_MSG, 32'h02);
    bus_write(A_MSG, 32'h09);
    repeat (LAT + 2) @(negedge clk);
    check(pulses == p0 + 1, "R9 not forwarded", pulses, p0 + 1);
    bus_read(A_RESP, r); check(r == 32'hFC, "R9 busy code", r, 32'hFC);
    bus_read(A_ARG, r);  check(r == 32'hCAFE_0001, "R9 arg kept", r, 32'hCAFE_0001);
    bus_read(A_MSG, r);  check(r == 32'h02, "R9 msg kept", r, 32'h02);

    // Random mix
    for (int i = 0; i < 40; i++) begin
      int k;
      logic [7:0] id;
      k = $urandom_range(0, 9);
      id = (k < 7) ? tbl[k] : 8'($urandom);
      do_cmd(id, $urandom);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule